// File: doc/BRIEF.md
# LCD multiplex backplane sequencer

This block produces the time base and the drive level codes for a passive segment display. It has up to four common (backplane) electrodes and a parameterised number of segment electrodes. One frame is a fixed number of clock cycles. The frame is cut into equal slots, one per backplane and per polarity. In each slot exactly one logical backplane is active. The segment data for that backplane is taken from one column of an external 4-bit-deep display RAM and held in a latch until the slot ends. Drive voltages are not produced here. Each electrode gets a 2-bit level index that an analog stage turns into a voltage.

Four drive modes are supported: static, 1:2, 1:3 and 1:4. In the modes with fewer than four backplanes, the unused backplane outputs copy active ones by a fixed rule, so they can be paired on the board. In static and 1:2 modes, the upper RAM bits can be shown in place of the lower ones. Software can then build the next picture in the spare bits and swap to it, or blink a chosen set of segments by toggling the bank input.

The RAM read port is a plain combinational lookup: the block puts out a column index and takes the data back in the same cycle. It never stalls, and the RAM side has no way to hold it back, so there is no valid/ready handshake on it. Mode and bank inputs are plain control pins. Each is sampled once per frame.

Top module: `lcd_mux_seq`

## Requirements
- R1: `frame_start` is high for exactly one cycle at the start of every frame. Consecutive pulses are FRAME_DIV cycles apart (default 24). The first pulse comes two cycles after reset is released.
- R2: With N backplanes (mode code 0 static N=1, 1 → N=2, 2 → N=3, 3 → N=4), a frame has 2N slots of FRAME_DIV/(2N) cycles each. The first N slots are positive polarity with logical phases 0..N-1 in order. The next N slots repeat that order with negative polarity.
- R3: Level codes are 0 = ground, 1 = one third, 2 = two thirds, 3 = full. Backplane k sits at bits [2k+1:2k] of `bp_lvl`. An active backplane is at 3 in positive polarity and 0 in negative polarity. An inactive one is at 1 (positive) or 2 (negative). In 1:4 mode, backplane k is active in phase k.
- R4: Segment i sits at bits [2i+1:2i] of `seg_lvl`. An on segment is at 0 (positive) or 3 (negative). An off segment is at 2 or 1 in multiplexed modes, and at 3 or 0 in static mode.
- R5: In 1:3 mode, backplanes 0–2 follow phases 0–2, and backplane 3 carries the same code as backplane 1.
- R6: In 1:2 mode, backplanes 0 and 2 follow phase 0, and backplanes 1 and 3 follow phase 1.
- R7: In static mode, all four backplanes carry the same code.
- R8: `ram_bits` is captured only in the last cycle of a slot (or the first cycle after reset). Changes at any other time do not alter `seg_lvl` before the next slot.
- R9: `ram_col` is the logical phase of the next slot. When `bank_alt` was high at the frame start, 2 is added to it in static and 1:2 modes: static shows column 2 instead of 0, and 1:2 shows columns 2/3 instead of 0/1.
- R10: In 1:3 and 1:4 modes, `bank_alt` has no effect, and `ram_col` equals the logical phase.
- R11: `drive_mode` and `bank_alt` are sampled only in the cycle before `frame_start`. Changes within a frame take effect at the next frame.
- R12: While `disp_en` is low, every level output is 0. Timing keeps running.
- R13: With RAM and enable held constant over a frame, the sum of (backplane level − segment level) over that frame is zero for every pair.
- R14: While reset is asserted with `disp_en` high, `frame_start` is 0 and every level output is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| disp_en | input | 1 | Display enable; low blanks all outputs to level 0 |
| drive_mode | input | 2 | 0 static, 1 → 1:2, 2 → 1:3, 3 → 1:4 |
| bank_alt | input | 1 | Show upper RAM bits (static and 1:2 only) |
| ram_bits | input | SEGS | Segment data of the column selected by `ram_col` |
| ram_col | output | 2 | RAM column to read for the next slot |
| frame_start | output | 1 | One-cycle pulse at the first cycle of each frame |
| seg_lvl | output | 2*SEGS | Segment level codes, 2 bits per segment |
| bp_lvl | output | 8 | Backplane level codes, 2 bits per backplane |

## Verification
The internal state is a slot counter, a phase/polarity pair, the sampled mode and bank, and the segment latch. A fault in any of them reaches the pins quickly. A miscounted slot moves `frame_start` and the backplane hand-over within one frame of 24 cycles. A wrong phase or polarity shows up on `bp_lvl` in the same cycle. A latch that captures at the wrong moment, or from the wrong column, shows up on `seg_lvl` within one slot, because the bench changes RAM contents between boundaries. A polarity schedule that is not balanced can only show over a whole frame, so the DC sum is checked at each frame boundary.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef enum logic [1:0] {
    MODE_STATIC = 2'd0,
    MODE_MUX2   = 2'd1,
    MODE_MUX3   = 2'd2,
    MODE_MUX4   = 2'd3
  } drive_mode_e;

  typedef logic [1:0] level_t;

  localparam level_t LVL_GND    = 2'd0;
  localparam level_t LVL_THIRD  = 2'd1;
  localparam level_t LVL_2THIRD = 2'd2;
  localparam level_t LVL_FULL   = 2'd3;

  // Logical phase in which physical backplane k is driven active.
  function automatic logic [1:0] bp_phase_map(drive_mode_e m, logic [1:0] k);
    logic [1:0] ph;
    case (m)
      MODE_STATIC: ph = 2'd0;
      MODE_MUX2:   ph = {1'b0, k[0]};
      MODE_MUX3:   ph = (k == 2'd3) ? 2'd1 : k;
      default:     ph = k;
    endcase
    return ph;
  endfunction

endpackage

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
  import lcd_seq_pkg::*;
#(
  parameter int FRAME_DIV = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  drive_mode_e mode_in,
  input  logic        bank_in,
  output logic        load,
  output logic        frame_new,
  output logic [1:0]  phase,
  output logic        pol,
  output drive_mode_e mode_q,
  output logic [1:0]  ram_col,
  output logic        frame_start
);

  localparam int CW = $clog2(FRAME_DIV / 2);

  logic          started;
  logic          bank_q;
  logic [CW-1:0] slot_cnt;
  logic [CW-1:0] slot_last;
  drive_mode_e   nxt_mode;
  logic          nxt_bank;
  logic [1:0]    nxt_phase;
  logic          nxt_pol;

  // Slot length = FRAME_DIV / (2 * backplanes)
  always_comb begin
    case (mode_q)
      MODE_STATIC: slot_last = CW'(FRAME_DIV / 2 - 1);
      MODE_MUX2:   slot_last = CW'(FRAME_DIV / 4 - 1);
      MODE_MUX3:   slot_last = CW'(FRAME_DIV / 6 - 1);
      default:     slot_last = CW'(FRAME_DIV / 8 - 1);
    endcase
  end

  always_comb begin
    load      = !started || (slot_cnt == slot_last);
    frame_new = load && (!started || (pol && (phase == mode_q)));
    nxt_mode  = frame_new ? mode_in : mode_q;
    nxt_bank  = frame_new ? bank_in : bank_q;
    if (frame_new) begin
      nxt_phase = 2'd0;
      nxt_pol   = 1'b0;
    end else if (phase == mode_q) begin
      nxt_phase = 2'd0;
      nxt_pol   = 1'b1;
    end else begin
      nxt_phase = 2'(phase + 2'd1);
      nxt_pol   = pol;
    end
    // alternate bank only reachable with one or two backplanes
    ram_col = (nxt_bank && !nxt_mode[1]) ? (nxt_phase | 2'd2) : nxt_phase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started     <= 1'b0;
      slot_cnt    <= '0;
      phase       <= 2'd0;
      pol         <= 1'b0;
      mode_q      <= MODE_STATIC;
      bank_q      <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      started     <= 1'b1;
      frame_start <= frame_new;
      if (load) begin
        slot_cnt <= '0;
        phase    <= nxt_phase;
        pol      <= nxt_pol;
        mode_q   <= nxt_mode;
        bank_q   <= nxt_bank;
      end else begin
        slot_cnt <= CW'(slot_cnt + 1'b1);
      end
    end
  end

endmodule

// File: rtl/lcd_seg_latch.sv
module lcd_seg_latch #(
  parameter int SEGS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [SEGS-1:0] ram_bits,
  output logic [SEGS-1:0] seg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    seg_q <= '0;
    else if (load) seg_q <= ram_bits;
  end

endmodule

// File: rtl/lcd_level_drive.sv
module lcd_level_drive
  import lcd_seq_pkg::*;
#(
  parameter int SEGS = 32,
  parameter int BPS  = 4
) (
  input  logic              disp_en,
  input  drive_mode_e       mode_q,
  input  logic [1:0]        phase,
  input  logic              pol,
  input  logic [SEGS-1:0]   seg_q,
  output logic [2*SEGS-1:0] seg_lvl,
  output logic [2*BPS-1:0]  bp_lvl
);

  level_t on_lvl, off_lvl, act_lvl, idle_lvl;

  always_comb begin
    on_lvl   = pol ? LVL_FULL : LVL_GND;
    act_lvl  = pol ? LVL_GND : LVL_FULL;
    idle_lvl = pol ? LVL_2THIRD : LVL_THIRD;
    if (mode_q == MODE_STATIC) off_lvl = act_lvl;
    else                       off_lvl = pol ? LVL_THIRD : LVL_2THIRD;
  end

  for (genvar i = 0; i < SEGS; i++) begin : g_seg
    assign seg_lvl[2*i +: 2] = !disp_en ? LVL_GND :
                               (seg_q[i] ? on_lvl : off_lvl);
  end

  for (genvar k = 0; k < BPS; k++) begin : g_bp
    logic active;
    assign active = (bp_phase_map(mode_q, 2'(k)) == phase);
    assign bp_lvl[2*k +: 2] = !disp_en ? LVL_GND :
                              (active ? act_lvl : idle_lvl);
  end

endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq
  import lcd_seq_pkg::*;
#(
  parameter int SEGS      = 32,
  parameter int FRAME_DIV = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_en,
  input  logic [1:0]        drive_mode,
  input  logic              bank_alt,
  input  logic [SEGS-1:0]   ram_bits,
  output logic [1:0]        ram_col,
  output logic              frame_start,
  output logic [2*SEGS-1:0] seg_lvl,
  output logic [7:0]        bp_lvl
);

  localparam int BPS = 4;

  logic            load;
  logic            frame_new;
  logic [1:0]      phase;
  logic            pol;
  drive_mode_e     mode_q;
  logic [SEGS-1:0] seg_q;

  lcd_frame_timer #(.FRAME_DIV(FRAME_DIV)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_in     (drive_mode_e'(drive_mode)),
    .bank_in     (bank_alt),
    .load        (load),
    .frame_new   (frame_new),
    .phase       (phase),
    .pol         (pol),
    .mode_q      (mode_q),
    .ram_col     (ram_col),
    .frame_start (frame_start)
  );

  lcd_seg_latch #(.SEGS(SEGS)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .ram_bits (ram_bits),
    .seg_q    (seg_q)
  );

  lcd_level_drive #(.SEGS(SEGS), .BPS(BPS)) u_drive (
    .disp_en (disp_en),
    .mode_q  (mode_q),
    .phase   (phase),
    .pol     (pol),
    .seg_q   (seg_q),
    .seg_lvl (seg_lvl),
    .bp_lvl  (bp_lvl)
  );

endmodule

// File: rtl/lcd_seq_checker.sv
module lcd_seq_checker #(
  parameter int SEGS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              disp_en,
  input logic [1:0]        drive_mode,
  input logic [1:0]        ram_col,
  input logic              frame_start,
  input logic [2*SEGS-1:0] seg_lvl,
  input logic [7:0]        bp_lvl,
  input logic              load,
  input logic              frame_new,
  input logic [1:0]        mode_q,
  input logic [SEGS-1:0]   seg_q
);

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(seg_q));

  a_r11_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_new |=> $stable(mode_q));

  a_r12_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_en |-> (bp_lvl == 8'd0 && seg_lvl == '0));

  a_r7_static_same: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0) |-> (bp_lvl[1:0] == bp_lvl[3:2] && bp_lvl[3:2] == bp_lvl[5:4]
                          && bp_lvl[5:4] == bp_lvl[7:6]));

  a_r6_mux2_pairs: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd1) |-> (bp_lvl[1:0] == bp_lvl[5:4] && bp_lvl[3:2] == bp_lvl[7:6]));

  a_r5_mux3_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd2) |-> (bp_lvl[7:6] == bp_lvl[3:2]));

  a_r10_no_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_new && drive_mode[1]) |-> (ram_col == 2'd0));

endmodule

bind lcd_mux_seq lcd_seq_checker #(.SEGS(SEGS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .disp_en     (disp_en),
  .drive_mode  (drive_mode),
  .ram_col     (ram_col),
  .frame_start (frame_start),
  .seg_lvl     (seg_lvl),
  .bp_lvl      (bp_lvl),
  .load        (load),
  .frame_new   (frame_new),
  .mode_q      (mode_q),
  .seg_q       (seg_q)
);

// File: tb/lcd_mux_seq_bench.sv
`timescale 1ns/1ps
module lcd_mux_seq_bench;

  localparam int SEGS = 32;
  localparam int FD   = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              disp_en = 1'b1;
  logic [1:0]        drive_mode = 2'd0;
  logic              bank_alt = 1'b0;
  logic [SEGS-1:0]   ram_bits;
  logic [1:0]        ram_col;
  logic              frame_start;
  logic [2*SEGS-1:0] seg_lvl;
  logic [7:0]        bp_lvl;

  logic [SEGS-1:0] mem [4];
  assign ram_bits = mem[ram_col];

  always #2 clk = ~clk;

  lcd_mux_seq #(.SEGS(SEGS), .FRAME_DIV(FD)) u_lcd_mux_seq (
    .clk(clk), .rst_n(rst_n), .disp_en(disp_en), .drive_mode(drive_mode),
    .bank_alt(bank_alt), .ram_bits(ram_bits), .ram_col(ram_col),
    .frame_start(frame_start), .seg_lvl(seg_lvl), .bp_lvl(bp_lvl));

  int tests = 0;
  int fails = 0;
  bit done = 0;
  string dir_tag = "";

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  bit m_started, m_pol, m_fs, m_bank;
  int m_cnt, m_ph, m_mode;
  logic [SEGS-1:0] m_latch;
  int n_last, n_mode, n_ph, n_col;
  bit n_ld, n_fn, n_bank, n_pol;

  always @* begin
    n_last = FD / (2 * (m_mode + 1)) - 1;
    n_ld   = !m_started || (m_cnt == n_last);
    n_fn   = n_ld && (!m_started || (m_pol && m_ph == m_mode));
    if (n_fn) begin
      n_mode = int'(drive_mode); n_bank = bank_alt; n_ph = 0; n_pol = 0;
    end else if (m_ph == m_mode) begin
      n_mode = m_mode; n_bank = m_bank; n_ph = 0; n_pol = 1;
    end else begin
      n_mode = m_mode; n_bank = m_bank; n_ph = m_ph + 1; n_pol = m_pol;
    end
    n_col = n_ph + ((n_bank && n_mode < 2) ? 2 : 0);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_started <= 0; m_cnt <= 0; m_ph <= 0; m_pol <= 0;
      m_mode <= 0; m_bank <= 0; m_latch <= '0; m_fs <= 0;
    end else begin
      m_started <= 1;
      m_fs <= n_fn;
      if (n_ld) begin
        m_cnt <= 0; m_ph <= n_ph; m_pol <= n_pol;
        m_mode <= n_mode; m_bank <= n_bank; m_latch <= mem[n_col];
      end else begin
        m_cnt <= m_cnt + 1;
      end
    end
  end

  function automatic logic [1:0] e_seg(bit on, int md, bit p, bit en);
    if (!en) return 2'd0;
    if (on) return p ? 2'd3 : 2'd0;
    if (md == 0) return p ? 2'd0 : 2'd3;
    return p ? 2'd1 : 2'd2;
  endfunction

  function automatic int phase_of(int k, int md);
    case (md)
      0: return 0;
      1: return k % 2;
      2: return (k == 3) ? 1 : k;
      default: return k;
    endcase
  endfunction

  function automatic logic [1:0] e_bp(int k, int md, int ph, bit p, bit en);
    if (!en) return 2'd0;
    if (phase_of(k, md) == ph) return p ? 2'd0 : 2'd3;
    return p ? 2'd2 : 2'd1;
  endfunction

  function automatic string bp_tag(int md);
    case (md)
      0: return "R2 R7";
      1: return "R2 R6";
      2: return "R2 R5";
      default: return "R2 R3";
    endcase
  endfunction

  // DC balance bookkeeping (R13)
  bit dc_on = 0;
  bit dc_full = 0;
  int dc_sum [8];

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [63:0] es;
      logic [7:0]  eb;
      string st, bt;
      for (int i = 0; i < SEGS; i++) es[2*i +: 2] = e_seg(m_latch[i], m_mode, m_pol, disp_en);
      for (int k = 0; k < 4; k++) eb[2*k +: 2] = e_bp(k, m_mode, m_ph, m_pol, disp_en);
      st = !disp_en ? "R12" : "R4";
      bt = !disp_en ? "R12" : bp_tag(m_mode);
      if (dir_tag == "R8") st = "R8";
      if (dir_tag == "R11") bt = "R11";
      chk("R1", 64'(frame_start), 64'(m_fs));
      chk((n_mode < 2) ? "R9" : "R10", 64'(ram_col), 64'(n_col));
      chk(bt, 64'(bp_lvl), 64'(eb));
      chk(st, seg_lvl, es);
      if (dc_on) begin
        if (frame_start) begin
          if (dc_full)
            for (int j = 0; j < 8; j++) chk("R13", 64'(dc_sum[j]), 64'd0);
          dc_full = 1;
          for (int j = 0; j < 8; j++) dc_sum[j] = 0;
        end
        for (int k = 0; k < 4; k++) begin
          dc_sum[k]   += int'(bp_lvl[2*k +: 2]) - int'(seg_lvl[1:0]);
          dc_sum[k+4] += int'(bp_lvl[2*k +: 2]) - int'(seg_lvl[63:62]);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd7305);
    for (int c = 0; c < 4; c++) mem[c] = $urandom;
    // R14: reset state
    step(3);
    @(negedge clk);
    chk("R14", 64'(frame_start), 64'd0);
    chk("R14", 64'(bp_lvl), 64'hFF);
    chk("R14", seg_lvl, {64{1'b1}});
    @(posedge clk); #1;
    rst_n = 1'b1;

    // directed: each mode and bank, constant RAM, DC balance
    for (int md = 0; md < 4; md++) begin
      for (int b = 0; b < 2; b++) begin
        drive_mode = 2'(md); bank_alt = 1'(b);
        dc_full = 0; dc_on = 1;
        step(4 * FD);
      end
    end
    dc_on = 0;

    // R11: mode change mid-frame
    drive_mode = 2'd3; bank_alt = 1'b0;
    step(2 * FD);
    @(posedge frame_start); step(5);
    dir_tag = "R11";
    drive_mode = 2'd0; bank_alt = 1'b1;
    step(FD + 4);
    dir_tag = "";

    // R8: RAM changes every cycle, latched only at slot boundaries
    dir_tag = "R8";
    for (int md = 0; md < 4; md++) begin
      drive_mode = 2'(md);
      for (int c = 0; c < 2 * FD; c++) begin
        mem[$urandom % 4] = $urandom;
        step(1);
      end
    end
    dir_tag = "";

    // R12: display off
    disp_en = 1'b0;
    step(30);
    disp_en = 1'b1;

    // random mix
    for (int c = 0; c < 3000; c++) begin
      if ($urandom % 16 == 0) drive_mode = 2'($urandom % 4);
      if ($urandom % 16 == 0) bank_alt = ~bank_alt;
      if ($urandom % 4 == 0) mem[$urandom % 4] = $urandom;
      disp_en = ($urandom % 20) != 0;
      step(1);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule